// File: doc/BRIEF.md
# Bus Controller Descriptor Stack Sequencer

This block does the memory bookkeeping for a serial-bus bus controller that runs frames of messages out of shared RAM. When a frame begins, it samples which of two structure sets (area A or area B) is active. It loads that area's stack pointer and message count. It then walks a circular stack of four-word message descriptors. For each descriptor it reads the gap-time word and the block address, fetches the control word from the start of the message block, and hands all three to a message engine.

The engine reports when each message begins and ends. Each report carries a status word. On both reports the sequencer writes the status into descriptor word 0 and the current time tag into word 1. After the end report it steps the pointer by one descriptor, wrapping inside the selected stack size, and counts the message off. When the count reaches zero it writes the pointer and count back to the active area and signals the end of the frame. In auto-repeat mode the starting pointer and count come from a separate pair of initial-value locations. The host can then restart the same frame without rewriting them.

Top module: `desc_stack_seq`

## Requirements
- R1: The RAM port makes at most one access per cycle and never reads and writes in the same cycle. Read data is taken from `ramRdata` one cycle after `ramRd` is high.
- R2: `areaSel` is sampled only on the `frameStart` that begins a frame. With 0, the area's locations sit at LOC_BASE+0..3. With 1, they sit at LOC_BASE+4..7. Changing `areaSel` during a frame does not change which locations are read or written back.
- R3: With `autoRepeat` low, the pointer is read from area offset 0 and the count from area offset 1. The initial-value locations at offsets 2 and 3 are neither used nor changed.
- R4: With `autoRepeat` high, the pointer is read from area offset 2 and the count from area offset 3.
- R5: For each message, the block reads descriptor words 2 (gap time) and 3 (block address), then the control word at the block address. It then raises `engStart` for exactly one cycle with `engBlkAddr`, `engCtrlWord` and `engGap` valid.
- R6: `engGap` equals the gap-time word when `gapEnable` is high and is zero otherwise.
- R7: On `msgBegin`, and again on `msgEnd`, `msgStatus` is written to descriptor word 0 and `timeTag` to descriptor word 1.
- R8: After `msgEnd`, the pointer advances by 4 inside a window of 256 << `stackSize` words (0=256, 1=512, 2=1024, 3=2048). The window-aligned upper address bits are kept.
- R9: When the count is zero, the block writes the advanced pointer to area offset 0 and zero to area offset 1, then pulses `frameDone` for one cycle and drops `busy`. A frame that starts with a count of zero runs no message.
- R10: A `frameStart` while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameStart | input | 1 | Pulse that begins a frame when idle |
| areaSel | input | 1 | Active area select (0 = A, 1 = B) |
| autoRepeat | input | 1 | Take the start pointer and count from the initial-value locations |
| gapEnable | input | 1 | Pass the gap-time word to the engine |
| stackSize | input | 2 | Stack window size code |
| timeTag | input | 16 | Current time tag value |
| ramAddr | output | ADDR_W | RAM word address |
| ramRd | output | 1 | RAM read strobe |
| ramWr | output | 1 | RAM write strobe |
| ramWdata | output | 16 | RAM write data |
| ramRdata | input | 16 | RAM read data, one cycle after the read |
| engStart | output | 1 | Message ready for the engine |
| engBlkAddr | output | ADDR_W | Message block start address |
| engCtrlWord | output | 16 | First word of the message block |
| engGap | output | 16 | Minimum delay before this message |
| msgBegin | input | 1 | Engine reports the message has begun |
| msgEnd | input | 1 | Engine reports the message has ended |
| msgStatus | input | 16 | Status word reported with begin or end |
| busy | output | 1 | Frame in progress |
| frameDone | output | 1 | One-cycle pulse at frame end |

## Verification
A corrupted pointer or window mask shows up on the very next `engStart`: the block address and control word presented no longer match the descriptor the stack walk should have reached. Status and time tags then land at the wrong addresses within a few cycles of the next begin report. A wrong count or a wrong latched area shows up later, at frame end. The result is an extra or missing `engStart`, or write-back to the wrong location pair, visible in the cycle `frameDone` rises. Mode errors show up at the first read, as a wrong start descriptor.

// File: rtl/desc_stack_pkg.sv
package desc_stack_pkg;

  typedef enum logic [3:0] {
    OP_NONE,
    OP_RD_PTRLOC,
    OP_RD_CNTLOC,
    OP_RD_GAP,
    OP_RD_BLK,
    OP_RD_CW,
    OP_WR_STS,
    OP_WR_TT,
    OP_WB_PTR,
    OP_WB_CNT
  } memOp_e;

  typedef enum logic [4:0] {
    S_IDLE,
    S_RD_PTR,
    S_RD_CNT,
    S_CHK_CNT,
    S_LOOP,
    S_RD_GAP,
    S_RD_BLK,
    S_CAP_BLK,
    S_RD_CW,
    S_CAP_CW,
    S_ISSUE,
    S_WAIT_BEG,
    S_WR_ST_B,
    S_WR_TT_B,
    S_WAIT_END,
    S_WR_ST_E,
    S_WR_TT_E,
    S_ADV,
    S_WB_PTR,
    S_WB_CNT,
    S_DONE
  } seqState_e;

  typedef struct packed {
    memOp_e op;
    logic   latchCfg;
    logic   ldPtr;
    logic   ldCnt;
    logic   ldGap;
    logic   ldBlk;
    logic   ldCw;
    logic   ldSts;
    logic   advance;
  } seqStrb_t;

endpackage

// File: rtl/desc_stack_ctrl.sv
module desc_stack_ctrl
  import desc_stack_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     frameStart,
  input  logic     msgBegin,
  input  logic     msgEnd,
  input  logic     cntZero,
  output seqStrb_t strb,
  output logic     busy,
  output logic     engStart,
  output logic     frameDone
);

  seqState_e stateQ, stateD;

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= S_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD = stateQ;
    strb   = '0;
    unique case (stateQ)
      S_IDLE: if (frameStart) begin
        strb.latchCfg = 1'b1;
        stateD = S_RD_PTR;
      end
      S_RD_PTR: begin
        strb.op = OP_RD_PTRLOC;
        stateD = S_RD_CNT;
      end
      S_RD_CNT: begin
        strb.op    = OP_RD_CNTLOC;
        strb.ldPtr = 1'b1;
        stateD = S_CHK_CNT;
      end
      S_CHK_CNT: begin
        strb.ldCnt = 1'b1;
        stateD = S_LOOP;
      end
      S_LOOP: stateD = cntZero ? S_WB_PTR : S_RD_GAP;
      S_RD_GAP: begin
        strb.op = OP_RD_GAP;
        stateD = S_RD_BLK;
      end
      S_RD_BLK: begin
        strb.op    = OP_RD_BLK;
        strb.ldGap = 1'b1;
        stateD = S_CAP_BLK;
      end
      S_CAP_BLK: begin
        strb.ldBlk = 1'b1;
        stateD = S_RD_CW;
      end
      S_RD_CW: begin
        strb.op = OP_RD_CW;
        stateD = S_CAP_CW;
      end
      S_CAP_CW: begin
        strb.ldCw = 1'b1;
        stateD = S_ISSUE;
      end
      S_ISSUE: stateD = S_WAIT_BEG;
      S_WAIT_BEG: if (msgBegin) begin
        strb.ldSts = 1'b1;
        stateD = S_WR_ST_B;
      end
      S_WR_ST_B: begin
        strb.op = OP_WR_STS;
        stateD = S_WR_TT_B;
      end
      S_WR_TT_B: begin
        strb.op = OP_WR_TT;
        stateD = S_WAIT_END;
      end
      S_WAIT_END: if (msgEnd) begin
        strb.ldSts = 1'b1;
        stateD = S_WR_ST_E;
      end
      S_WR_ST_E: begin
        strb.op = OP_WR_STS;
        stateD = S_WR_TT_E;
      end
      S_WR_TT_E: begin
        strb.op = OP_WR_TT;
        stateD = S_ADV;
      end
      S_ADV: begin
        strb.advance = 1'b1;
        stateD = S_LOOP;
      end
      S_WB_PTR: begin
        strb.op = OP_WB_PTR;
        stateD = S_WB_CNT;
      end
      S_WB_CNT: begin
        strb.op = OP_WB_CNT;
        stateD = S_DONE;
      end
      S_DONE: stateD = S_IDLE;
      default: stateD = S_IDLE;
    endcase
  end

  assign busy      = (stateQ != S_IDLE);
  assign engStart  = (stateQ == S_ISSUE);
  assign frameDone = (stateQ == S_DONE);

endmodule

// File: rtl/desc_stack_dp.sv
module desc_stack_dp
  import desc_stack_pkg::*;
#(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned LOC_BASE = 'hFF0
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrb_t          strb,
  input  logic              areaSel,
  input  logic              autoRepeat,
  input  logic              gapEnable,
  input  logic [1:0]        stackSize,
  input  logic [DATA_W-1:0] timeTag,
  input  logic [DATA_W-1:0] msgStatus,
  input  logic [DATA_W-1:0] ramRdata,
  output logic [ADDR_W-1:0] ramAddr,
  output logic              ramRd,
  output logic              ramWr,
  output logic [DATA_W-1:0] ramWdata,
  output logic [ADDR_W-1:0] engBlkAddr,
  output logic [DATA_W-1:0] engCtrlWord,
  output logic [DATA_W-1:0] engGap,
  output logic              cntZero
);

  localparam logic [ADDR_W-1:0] LOC_A    = ADDR_W'(LOC_BASE);
  localparam logic [ADDR_W-1:0] MIN_WIN  = ADDR_W'(256);
  localparam int unsigned       PAD_W    = DATA_W - ADDR_W;

  logic              areaReg, autoReg;
  logic [ADDR_W-1:0] maskReg, ptrReg, blkReg;
  logic [DATA_W-1:0] cntReg, gapReg, cwReg, stsReg;
  logic [ADDR_W-1:0] locBase;

  function automatic logic [ADDR_W-1:0] wrapAdd(
    input logic [ADDR_W-1:0] base,
    input logic [ADDR_W-1:0] step,
    input logic [ADDR_W-1:0] mask
  );
    return (base & ~mask) | ((base + step) & mask);
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      areaReg <= 1'b0;
      autoReg <= 1'b0;
      maskReg <= MIN_WIN - ADDR_W'(1);
      ptrReg  <= '0;
      cntReg  <= '0;
      gapReg  <= '0;
      blkReg  <= '0;
      cwReg   <= '0;
      stsReg  <= '0;
    end else begin
      if (strb.latchCfg) begin
        areaReg <= areaSel;
        autoReg <= autoRepeat;
        maskReg <= (MIN_WIN << stackSize) - ADDR_W'(1);
      end
      if (strb.ldPtr)   ptrReg <= ramRdata[ADDR_W-1:0];
      if (strb.ldCnt)   cntReg <= ramRdata;
      if (strb.ldGap)   gapReg <= ramRdata;
      if (strb.ldBlk)   blkReg <= ramRdata[ADDR_W-1:0];
      if (strb.ldCw)    cwReg  <= ramRdata;
      if (strb.ldSts)   stsReg <= msgStatus;
      if (strb.advance) begin
        ptrReg <= wrapAdd(ptrReg, ADDR_W'(4), maskReg);
        cntReg <= cntReg - DATA_W'(1);
      end
    end
  end

  assign locBase = LOC_A + {{(ADDR_W-3){1'b0}}, areaReg, 2'b00};

  always_comb begin
    ramAddr  = '0;
    ramRd    = 1'b0;
    ramWr    = 1'b0;
    ramWdata = '0;
    unique case (strb.op)
      OP_RD_PTRLOC: begin
        ramRd   = 1'b1;
        ramAddr = locBase + (autoReg ? ADDR_W'(2) : ADDR_W'(0));
      end
      OP_RD_CNTLOC: begin
        ramRd   = 1'b1;
        ramAddr = locBase + (autoReg ? ADDR_W'(3) : ADDR_W'(1));
      end
      OP_RD_GAP: begin
        ramRd   = 1'b1;
        ramAddr = wrapAdd(ptrReg, ADDR_W'(2), maskReg);
      end
      OP_RD_BLK: begin
        ramRd   = 1'b1;
        ramAddr = wrapAdd(ptrReg, ADDR_W'(3), maskReg);
      end
      OP_RD_CW: begin
        ramRd   = 1'b1;
        ramAddr = blkReg;
      end
      OP_WR_STS: begin
        ramWr    = 1'b1;
        ramAddr  = ptrReg;
        ramWdata = stsReg;
      end
      OP_WR_TT: begin
        ramWr    = 1'b1;
        ramAddr  = wrapAdd(ptrReg, ADDR_W'(1), maskReg);
        ramWdata = timeTag;
      end
      OP_WB_PTR: begin
        ramWr    = 1'b1;
        ramAddr  = locBase;
        ramWdata = {{PAD_W{1'b0}}, ptrReg};
      end
      OP_WB_CNT: begin
        ramWr    = 1'b1;
        ramAddr  = locBase + ADDR_W'(1);
        ramWdata = cntReg;
      end
      default: ;
    endcase
  end

  assign engBlkAddr  = blkReg;
  assign engCtrlWord = cwReg;
  assign engGap      = gapEnable ? gapReg : '0;
  assign cntZero     = (cntReg == '0);

endmodule

// File: rtl/desc_stack_seq.sv
module desc_stack_seq
  import desc_stack_pkg::*;
#(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned LOC_BASE = 'hFF0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameStart,
  input  logic              areaSel,
  input  logic              autoRepeat,
  input  logic              gapEnable,
  input  logic [1:0]        stackSize,
  input  logic [DATA_W-1:0] timeTag,
  output logic [ADDR_W-1:0] ramAddr,
  output logic              ramRd,
  output logic              ramWr,
  output logic [DATA_W-1:0] ramWdata,
  input  logic [DATA_W-1:0] ramRdata,
  output logic              engStart,
  output logic [ADDR_W-1:0] engBlkAddr,
  output logic [DATA_W-1:0] engCtrlWord,
  output logic [DATA_W-1:0] engGap,
  input  logic              msgBegin,
  input  logic              msgEnd,
  input  logic [DATA_W-1:0] msgStatus,
  output logic              busy,
  output logic              frameDone
);

  seqStrb_t strb;
  logic     cntZero;

  desc_stack_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .frameStart(frameStart),
    .msgBegin  (msgBegin),
    .msgEnd    (msgEnd),
    .cntZero   (cntZero),
    .strb      (strb),
    .busy      (busy),
    .engStart  (engStart),
    .frameDone (frameDone)
  );

  desc_stack_dp #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .LOC_BASE(LOC_BASE)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .areaSel    (areaSel),
    .autoRepeat (autoRepeat),
    .gapEnable  (gapEnable),
    .stackSize  (stackSize),
    .timeTag    (timeTag),
    .msgStatus  (msgStatus),
    .ramRdata   (ramRdata),
    .ramAddr    (ramAddr),
    .ramRd      (ramRd),
    .ramWr      (ramWr),
    .ramWdata   (ramWdata),
    .engBlkAddr (engBlkAddr),
    .engCtrlWord(engCtrlWord),
    .engGap     (engGap),
    .cntZero    (cntZero)
  );

endmodule

// File: rtl/desc_stack_chk.sv
module desc_stack_chk #(
  parameter int unsigned DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              ramRd,
  input logic              ramWr,
  input logic              engStart,
  input logic [DATA_W-1:0] engGap,
  input logic              gapEnable,
  input logic              frameDone,
  input logic              busy
);

  // R1: one access per cycle
  a_r1_single_access: assert property (@(posedge clk) disable iff (!rstN)
    !(ramRd && ramWr));

  // R5: engine start is a single-cycle pulse
  a_r5_start_pulse: assert property (@(posedge clk) disable iff (!rstN)
    engStart |=> !engStart);

  // R6: gap forced to zero when the feature is off
  a_r6_gap_masked: assert property (@(posedge clk) disable iff (!rstN)
    (engStart && !gapEnable) |-> (engGap == '0));

  // R9: frame end pulse is one cycle and leaves the block idle
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |=> (!frameDone && !busy));

  // R10: messages are only issued inside a frame
  a_r10_start_in_frame: assert property (@(posedge clk) disable iff (!rstN)
    engStart |-> busy);

endmodule

bind desc_stack_seq desc_stack_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .ramRd    (ramRd),
  .ramWr    (ramWr),
  .engStart (engStart),
  .engGap   (engGap),
  .gapEnable(gapEnable),
  .frameDone(frameDone),
  .busy     (busy)
);

// File: tb/desc_stack_seq_bench.sv
`timescale 1ns/1ps
module desc_stack_seq_bench;

  localparam int AW  = 12;
  localparam int DW  = 16;
  localparam int LOC = 'hFF0;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameStart = 0, areaSel = 0, autoRepeat = 0, gapEnable = 0;
  logic [1:0] stackSize = 0;
  logic [DW-1:0] timeTag = 0, msgStatus = 0;
  logic msgBegin = 0, msgEnd = 0;
  logic [AW-1:0] ramAddr;
  logic ramRd, ramWr;
  logic [DW-1:0] ramWdata;
  logic [DW-1:0] ramRdata = 0;
  logic engStart, busy, frameDone;
  logic [AW-1:0] engBlkAddr;
  logic [DW-1:0] engCtrlWord, engGap;

  logic [DW-1:0] mem [0:(1<<AW)-1];
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  desc_stack_seq u_desc_stack_seq (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .areaSel(areaSel),
    .autoRepeat(autoRepeat), .gapEnable(gapEnable), .stackSize(stackSize),
    .timeTag(timeTag), .ramAddr(ramAddr), .ramRd(ramRd), .ramWr(ramWr),
    .ramWdata(ramWdata), .ramRdata(ramRdata), .engStart(engStart),
    .engBlkAddr(engBlkAddr), .engCtrlWord(engCtrlWord), .engGap(engGap),
    .msgBegin(msgBegin), .msgEnd(msgEnd), .msgStatus(msgStatus),
    .busy(busy), .frameDone(frameDone)
  );

  always @(posedge clk) begin
    if (ramRd) ramRdata <= mem[ramAddr];
    if (ramWr) mem[ramAddr] <= ramWdata;
  end

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  function automatic logic [AW-1:0] nextPtr(input logic [AW-1:0] p, input logic [1:0] sel);
    logic [AW-1:0] m;
    m = (AW'(256) << sel) - AW'(1);
    return (p & ~m) | ((p + AW'(4)) & m);
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic waitEng(input string req, output bit ok);
    ok = 0;
    for (int t = 0; t < 100; t++) begin
      if (engStart) begin ok = 1; break; end
      @(negedge clk);
    end
    if (!ok) check({req, " engStart timeout"}, 0, 1);
  endtask

  task automatic runFrame(input bit area, input bit autoM, input logic [1:0] sel,
                          input int nMsg, input bit gapEn, input bit flipArea,
                          input bit extraStart, input bit nearEnd);
    int size;
    logic [AW-1:0] lb, ob, p, startPtr;
    logic [DW-1:0] gaps [8];
    logic [AW-1:0] blks [8];
    logic [DW-1:0] cws [8];
    logic [DW-1:0] other [4];
    logic [DW-1:0] initSave [2];
    bit ok;
    size = 256 << sel;
    lb = AW'(LOC) + (area ? AW'(4) : AW'(0));
    ob = AW'(LOC) + (area ? AW'(0) : AW'(4));
    startPtr = nearEnd ? AW'(size - 8) : AW'(($urandom % (size / 4)) * 4);
    for (int k = 0; k < 4; k++) begin
      other[k] = DW'($urandom);
      mem[ob + AW'(k)] = other[k];
    end
    if (autoM) begin
      mem[lb + 2] = DW'(startPtr);
      mem[lb + 3] = DW'(nMsg);
      mem[lb + 0] = 16'h0AB4;
      mem[lb + 1] = 16'h0077;
    end else begin
      mem[lb + 0] = DW'(startPtr);
      mem[lb + 1] = DW'(nMsg);
      mem[lb + 2] = 16'h0124;
      mem[lb + 3] = 16'h0033;
    end
    initSave[0] = mem[lb + 2];
    initSave[1] = mem[lb + 3];
    p = startPtr;
    for (int i = 0; i < nMsg; i++) begin
      gaps[i] = DW'($urandom);
      blks[i] = AW'('h800 + i * 16 + ($urandom % 8));
      cws[i]  = DW'($urandom);
      mem[p + 2] = gaps[i];
      mem[p + 3] = DW'(blks[i]);
      mem[blks[i]] = cws[i];
      p = nextPtr(p, sel);
    end
    areaSel = area; autoRepeat = autoM; stackSize = sel; gapEnable = gapEn;
    frameStart = 1; cyc(1); frameStart = 0;
    if (flipArea) begin cyc(2); areaSel = ~area; end
    p = startPtr;
    for (int i = 0; i < nMsg; i++) begin
      waitEng("R5", ok);
      if (!ok) return;
      check("R5 blk addr", engBlkAddr, blks[i]);
      check("R5 ctrl word", engCtrlWord, cws[i]);
      check("R6 gap", engGap, gapEn ? gaps[i] : 16'h0);
      cyc(1);
      if (extraStart && i == 0) begin frameStart = 1; cyc(1); frameStart = 0; end
      timeTag = DW'($urandom); msgStatus = DW'($urandom);
      msgBegin = 1; cyc(1); msgBegin = 0; cyc(4);
      check("R7 begin status", mem[p], msgStatus);
      check("R7 begin time tag", mem[p + 1], timeTag);
      timeTag = DW'($urandom); msgStatus = DW'($urandom);
      msgEnd = 1; cyc(1); msgEnd = 0; cyc(4);
      check("R7 end status", mem[p], msgStatus);
      check("R7 end time tag", mem[p + 1], timeTag);
      p = nextPtr(p, sel);
    end
    ok = 0;
    for (int t = 0; t < 100; t++) begin
      if (engStart) begin check("R9 R10 extra message", 1, 0); break; end
      if (frameDone) begin ok = 1; break; end
      @(negedge clk);
    end
    check("R9 frameDone seen", ok, 1);
    cyc(1);
    check("R9 busy low after frame", busy, 0);
    check("R8 R9 pointer write-back", mem[lb], DW'(p));
    check("R9 count write-back", mem[lb + 1], 0);
    check("R3 R4 initial locations kept", {mem[lb + 2], mem[lb + 3]}, {initSave[0], initSave[1]});
    for (int k = 0; k < 4; k++)
      check("R2 other area untouched", mem[ob + AW'(k)], other[k]);
    areaSel = 0;
    cyc(2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int a = 0; a < (1 << AW); a++) mem[a] = '0;
    cyc(3);
    check("R1 reset ramRd", ramRd, 0);
    check("R1 reset ramWr", ramWr, 0);
    check("R9 reset busy", busy, 0);
    check("R5 reset engStart", engStart, 0);
    rstN = 1;
    cyc(2);
    // R3 single-frame, area A, 256-word window
    runFrame(0, 0, 2'd0, 3, 1, 0, 0, 0);
    // R4 auto-repeat, area B, wrap in 512-word window (R8)
    runFrame(1, 1, 2'd1, 4, 1, 0, 0, 1);
    // R9 zero-count frame
    runFrame(0, 0, 2'd0, 0, 1, 0, 0, 0);
    // R2 area changed mid-frame, R6 gap disabled, 1024-word wrap
    runFrame(1, 0, 2'd2, 3, 0, 1, 0, 1);
    // R10 frameStart while busy, 2048-word wrap
    runFrame(0, 1, 2'd3, 2, 1, 0, 1, 1);
    for (int f = 0; f < 8; f++)
      runFrame($urandom % 2, $urandom % 2, 2'($urandom % 4), $urandom % 6,
               $urandom % 2, $urandom % 2, $urandom % 2, $urandom % 2);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule